// File: doc/BRIEF.md
# Multi-Bank IN Endpoint Transmit Buffer

This block manages the transmit side of a single device IN endpoint that has one to three data banks. Software fills the bank it currently owns one byte at a time, then hands that bank to the host side. When the host asks for data, the block answers with the oldest handed-over bank and its byte count. If no bank is waiting, it answers with a NAK. When the host acknowledges a bank, that bank returns to software. When the host times out, the bank stays queued and is offered again.

Software works through a pair of flags. `sw_own` shows that software holds the current bank. `bank_ready` is a sticky notice that a free bank has arrived and can raise the interrupt. Both flags are set together when the current bank becomes free. Releasing a bank moves software to the next bank, and both flags then reload from that bank's state. Token decoding, CRC, the serial line and OUT traffic belong to the neighbouring logic. Host requests arrive as an `in_token` strobe, and the handshake outcome returns as `tx_ack` or `tx_timeout`.

Top module: `inep_tx_buffer`

## Requirements
- R1: While `cfg_en` is low, all bank state is cleared and `sw_own`, `bank_ready`, `wr_room` and `irq` are 0. An `in_token` produces neither `tx_valid` nor `tx_nak`.
- R2: When the software-side bank is free and `sw_own` is 0, `sw_own` and `bank_ready` rise together on the next clock edge. This happens one edge after `cfg_en` rises, and on the edge that frees the bank.
- R3: `irq` is 1 exactly when `bank_ready` and the interrupt enable are both 1. A pulse on `sw_irq_en_set` sets the enable, and a pulse on `sw_irq_en_clr` clears it. Set wins when both pulse together.
- R4: A pulse on `sw_ready_ack` clears `bank_ready` only. `sw_own`, `sw_count` and `sw_bank` are unchanged.
- R5: A pulse on `sw_release` while `sw_own` is 1 hands the current bank to the host side. The next `in_token` is answered with `tx_valid`=1, `tx_bank` set to that bank and `tx_len` set to its byte count.
- R6: A release advances `sw_bank` by one, wrapping from NUM_BANKS-1 to 0. `sw_own` and `bank_ready` then both become 1 if the new bank is free, and both become 0 if it is still held by the host side.
- R7: `wr_room` is 1 exactly when `sw_own` is 1 and `sw_count` is below `cfg_size`.
- R8: An `in_token` is answered with `tx_nak`=1 and `tx_valid`=0 one cycle later in two cases: when the host-side bank is not handed over, or when a transfer is already awaiting its handshake.
- R9: `tx_ack` during an outstanding transfer frees that bank and zeroes its count. The host side then moves to the next bank.
- R10: Each bank has its own byte counter. An accepted write stores `sw_wr_data` at byte index `sw_count` and increments the counter. `tx_rd_data` returns byte `tx_rd_idx` of the host-side bank. A bank released with no bytes is sent with `tx_len`=0.
- R11: `tx_timeout` during an outstanding transfer keeps the bank handed over. The next `in_token` sends the same bank again with the same length.
- R12: `sw_wr_en` is ignored while `sw_own` is 0 or the current bank holds `cfg_size` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Endpoint configured and enabled |
| cfg_size | input | CNT_W | Bank capacity in bytes (1..BANK_BYTES) |
| sw_wr_en | input | 1 | Software byte write strobe |
| sw_wr_data | input | DATA_W | Software write byte |
| sw_ready_ack | input | 1 | Clear the bank-ready flag |
| sw_release | input | 1 | Hand the current bank to the host side |
| sw_irq_en_set | input | 1 | Set the interrupt enable |
| sw_irq_en_clr | input | 1 | Clear the interrupt enable |
| bank_ready | output | 1 | Free bank arrived (interrupt source) |
| sw_own | output | 1 | Software owns the current bank |
| wr_room | output | 1 | Current bank accepts another byte |
| irq | output | 1 | Endpoint interrupt |
| sw_bank | output | IDX_W | Software-side bank index |
| sw_count | output | CNT_W | Byte count of the software-side bank |
| in_token | input | 1 | Host data request strobe |
| tx_ack | input | 1 | Host acknowledged the transfer |
| tx_timeout | input | 1 | Host did not acknowledge |
| tx_valid | output | 1 | Data response pulse |
| tx_nak | output | 1 | NAK response pulse |
| tx_bank | output | IDX_W | Bank being sent |
| tx_len | output | CNT_W | Byte count being sent |
| tx_rd_idx | input | ADDR_W | Byte index into the host-side bank |
| tx_rd_data | output | DATA_W | Byte read from the host-side bank |

## Verification
The bench builds the block with NUM_BANKS=2 and BANK_BYTES=4, and sets `cfg_size` to 4. With these values a bank fills after four writes, so the ignored fifth write is easy to reach. The software pointer wraps after two releases, which brings up the case where the reload finds the next bank still held by the host. The host pointer also wraps, so acknowledge, timeout-retry and the zero-length bank are all exercised across both banks.

// File: rtl/inep_pkg.sv
package inep_pkg;
   typedef int unsigned uint_t;

   // next bank index, wrapping at the configured bank count
   function automatic uint_t bank_after(input uint_t cur, input uint_t nbanks);
      return (cur + 1 >= nbanks) ? 0 : cur + 1;
   endfunction
endpackage

// File: rtl/inep_bank_store.sv
module inep_bank_store #(
   parameter int NUM_BANKS  = 2,
   parameter int BANK_BYTES = 8,
   parameter int DATA_W     = 8,
   localparam int CNT_W  = $clog2(BANK_BYTES + 1),
   localparam int IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic                              wr_acc,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              commit_evt,
   input  logic [IDX_W-1:0]                  commit_idx,
   input  logic                              free_evt,
   input  logic [IDX_W-1:0]                  free_idx,
   input  logic [IDX_W-1:0]                  rd_bank,
   input  logic [ADDR_W-1:0]                 rd_idx,
   output logic [DATA_W-1:0]                 rd_data,
   output logic [NUM_BANKS-1:0]              held_o,
   output logic [NUM_BANKS-1:0][CNT_W-1:0]   cnt_o
);
   if (BANK_BYTES < 1) begin : g_bad_bytes
      $error("BANK_BYTES must be at least 1");
   end

   logic [NUM_BANKS-1:0][DATA_W-1:0] rd_word;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0]  cnt_q;
      logic              held_q;
      logic [DATA_W-1:0] mem [BANK_BYTES];
      logic              wr_here;

      assign wr_here = wr_acc && (wr_idx == IDX_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            cnt_q  <= '0;
            held_q <= 1'b0;
         end else if (free_evt && (free_idx == IDX_W'(b))) begin
            cnt_q  <= '0;
            held_q <= 1'b0;
         end else begin
            if (commit_evt && (commit_idx == IDX_W'(b))) held_q <= 1'b1;
            if (wr_here) cnt_q <= cnt_q + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_here) mem[ADDR_W'(cnt_q)] <= wr_data;
      end

      assign cnt_o[b]   = cnt_q;
      assign held_o[b]  = held_q;
      assign rd_word[b] = mem[rd_idx];
   end

   assign rd_data = rd_word[rd_bank];

   // the software side only hands over a bank it owns
   AST_COMMIT_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_evt && !clr) |-> !held_o[commit_idx]);   // R5
   // the host side only frees a bank it holds
   AST_FREE_HELD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (free_evt && !clr) |-> held_o[free_idx]);        // R9
   // a write never lands in a bank held by the host
   AST_WRITE_OWNED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !clr) |-> !held_o[wr_idx]);           // R12
endmodule

// File: rtl/inep_sw_ctrl.sv
module inep_sw_ctrl
   import inep_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int CNT_W     = 4,
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic [CNT_W-1:0]                 cfg_size,
   input  logic [NUM_BANKS-1:0]             held,
   input  logic [NUM_BANKS-1:0][CNT_W-1:0]  cnt,
   input  logic                             wr_en,
   input  logic                             ready_ack,
   input  logic                             release_req,
   input  logic                             irq_en_set,
   input  logic                             irq_en_clr,
   input  logic                             free_evt,
   input  logic [IDX_W-1:0]                 free_idx,
   output logic                             wr_acc,
   output logic                             commit_evt,
   output logic [IDX_W-1:0]                 sw_ptr,
   output logic [CNT_W-1:0]                 sw_cnt,
   output logic                             bank_ready,
   output logic                             sw_own,
   output logic                             wr_room,
   output logic                             irq
);
   logic                 irq_en_q;
   logic [IDX_W-1:0]     ptr_nx;
   logic [NUM_BANKS-1:0] held_nx;
   logic                 own_nx;
   logic                 rdy_nx;

   assign sw_cnt     = cnt[sw_ptr];
   assign wr_room    = sw_own && (sw_cnt < cfg_size);
   assign wr_acc     = en && wr_en && wr_room;
   assign commit_evt = en && release_req && sw_own;
   assign irq        = bank_ready && irq_en_q;

   always_comb begin
      ptr_nx  = commit_evt ? IDX_W'(bank_after(uint_t'(sw_ptr), NUM_BANKS)) : sw_ptr;
      held_nx = held;
      if (free_evt)   held_nx[free_idx] = 1'b0;
      if (commit_evt) held_nx[sw_ptr]   = 1'b1;
      own_nx = sw_own;
      rdy_nx = bank_ready;
      if (commit_evt) begin
         own_nx = !held_nx[ptr_nx];
         rdy_nx = own_nx;
      end else begin
         if (ready_ack) rdy_nx = 1'b0;
         if (!sw_own && !held_nx[sw_ptr]) begin
            own_nx = 1'b1;
            rdy_nx = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         sw_ptr     <= '0;
         sw_own     <= 1'b0;
         bank_ready <= 1'b0;
      end else begin
         sw_ptr     <= ptr_nx;
         sw_own     <= own_nx;
         bank_ready <= rdy_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          irq_en_q <= 1'b0;
      else if (irq_en_set) irq_en_q <= 1'b1;
      else if (irq_en_clr) irq_en_q <= 1'b0;
   end

   // the ready notice is never pending without ownership
   AST_READY_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ready |-> sw_own);                                  // R2
   // acknowledging the notice leaves ownership and pointer alone
   AST_ACK_KEEPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ready_ack && !release_req && sw_own) |=> sw_own && (sw_ptr == $past(sw_ptr)));  // R4
   // set strobe wins over clear strobe
   AST_IRQ_EN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_set && bank_ready && en && !release_req && !ready_ack) |=> irq);  // R3
endmodule

// File: rtl/inep_host_ctrl.sv
module inep_host_ctrl
   import inep_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int CNT_W     = 4,
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic [NUM_BANKS-1:0]             held,
   input  logic [NUM_BANKS-1:0][CNT_W-1:0]  cnt,
   input  logic                             in_token,
   input  logic                             tx_ack,
   input  logic                             tx_timeout,
   output logic [IDX_W-1:0]                 hw_ptr,
   output logic                             tx_valid,
   output logic                             tx_nak,
   output logic [IDX_W-1:0]                 tx_bank,
   output logic [CNT_W-1:0]                 tx_len,
   output logic                             free_evt,
   output logic [IDX_W-1:0]                 free_idx
);
   logic busy_q;
   logic send_ok;

   assign send_ok  = held[hw_ptr] && !busy_q;
   assign free_evt = en && busy_q && tx_ack;
   assign free_idx = hw_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         hw_ptr   <= '0;
         busy_q   <= 1'b0;
         tx_valid <= 1'b0;
         tx_nak   <= 1'b0;
         tx_bank  <= '0;
         tx_len   <= '0;
      end else begin
         tx_valid <= in_token && send_ok;
         tx_nak   <= in_token && !send_ok;
         if (in_token && send_ok) begin
            busy_q  <= 1'b1;
            tx_bank <= hw_ptr;
            tx_len  <= cnt[hw_ptr];
         end else if (busy_q && (tx_ack || tx_timeout)) begin
            busy_q <= 1'b0;
         end
         if (free_evt) hw_ptr <= IDX_W'(bank_after(uint_t'(hw_ptr), NUM_BANKS));
      end
   end

   AST_NAK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (en && in_token && !held[hw_ptr]) |=> tx_nak && !tx_valid);            // R8
   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && tx_nak));                                                // R8
   AST_RETRY_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy_q && tx_timeout && !tx_ack) |=> !busy_q && (hw_ptr == $past(hw_ptr)));  // R11
   AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy_q && tx_ack) |=> !busy_q);                                 // R9
endmodule

// File: rtl/inep_tx_buffer.sv
module inep_tx_buffer #(
   parameter int NUM_BANKS  = 2,
   parameter int BANK_BYTES = 8,
   parameter int DATA_W     = 8,
   localparam int CNT_W  = $clog2(BANK_BYTES + 1),
   localparam int IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [CNT_W-1:0]  cfg_size,
   input  logic              sw_wr_en,
   input  logic [DATA_W-1:0] sw_wr_data,
   input  logic              sw_ready_ack,
   input  logic              sw_release,
   input  logic              sw_irq_en_set,
   input  logic              sw_irq_en_clr,
   output logic              bank_ready,
   output logic              sw_own,
   output logic              wr_room,
   output logic              irq,
   output logic [IDX_W-1:0]  sw_bank,
   output logic [CNT_W-1:0]  sw_count,
   input  logic              in_token,
   input  logic              tx_ack,
   input  logic              tx_timeout,
   output logic              tx_valid,
   output logic              tx_nak,
   output logic [IDX_W-1:0]  tx_bank,
   output logic [CNT_W-1:0]  tx_len,
   input  logic [ADDR_W-1:0] tx_rd_idx,
   output logic [DATA_W-1:0] tx_rd_data
);
   if (NUM_BANKS < 1 || NUM_BANKS > 3) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..3");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic [NUM_BANKS-1:0]            bank_held;
   logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt;
   logic                            wr_acc;
   logic                            commit_evt;
   logic                            free_evt;
   logic [IDX_W-1:0]                free_idx;
   logic [IDX_W-1:0]                hw_ptr;

   inep_bank_store #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(!cfg_en),
      .wr_acc(wr_acc), .wr_idx(sw_bank), .wr_data(sw_wr_data),
      .commit_evt(commit_evt), .commit_idx(sw_bank),
      .free_evt(free_evt), .free_idx(free_idx),
      .rd_bank(hw_ptr), .rd_idx(tx_rd_idx), .rd_data(tx_rd_data),
      .held_o(bank_held), .cnt_o(bank_cnt)
   );

   inep_sw_ctrl #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_sw (
      .clk(clk), .rst_n(rst_n), .en(cfg_en), .cfg_size(cfg_size),
      .held(bank_held), .cnt(bank_cnt),
      .wr_en(sw_wr_en), .ready_ack(sw_ready_ack), .release_req(sw_release),
      .irq_en_set(sw_irq_en_set), .irq_en_clr(sw_irq_en_clr),
      .free_evt(free_evt), .free_idx(free_idx),
      .wr_acc(wr_acc), .commit_evt(commit_evt), .sw_ptr(sw_bank), .sw_cnt(sw_count),
      .bank_ready(bank_ready), .sw_own(sw_own), .wr_room(wr_room), .irq(irq)
   );

   inep_host_ctrl #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_host (
      .clk(clk), .rst_n(rst_n), .en(cfg_en),
      .held(bank_held), .cnt(bank_cnt),
      .in_token(in_token), .tx_ack(tx_ack), .tx_timeout(tx_timeout),
      .hw_ptr(hw_ptr), .tx_valid(tx_valid), .tx_nak(tx_nak),
      .tx_bank(tx_bank), .tx_len(tx_len),
      .free_evt(free_evt), .free_idx(free_idx)
   );

   AST_RELEASE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && sw_release && sw_own) |=> bank_held[$past(sw_bank)]);        // R5
   AST_IGNORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && sw_wr_en && sw_own && !wr_room && !sw_release) |=> (sw_count == $past(sw_count)));  // R12
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !tx_valid && !tx_nak && !sw_own);                           // R1
endmodule

// File: tb/inep_tx_buffer_tb.sv
module inep_tx_buffer_tb;
   localparam int NB = 2;
   localparam int BB = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b0;
   logic [2:0] cfg_size = 3'd4;
   logic       sw_wr_en = 1'b0;
   logic [7:0] sw_wr_data = '0;
   logic       sw_ready_ack = 1'b0, sw_release = 1'b0;
   logic       sw_irq_en_set = 1'b0, sw_irq_en_clr = 1'b0;
   logic       bank_ready, sw_own, wr_room, irq;
   logic [0:0] sw_bank, tx_bank;
   logic [2:0] sw_count, tx_len;
   logic       in_token = 1'b0, tx_ack = 1'b0, tx_timeout = 1'b0;
   logic       tx_valid, tx_nak;
   logic [1:0] tx_rd_idx = '0;
   logic [7:0] tx_rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   inep_tx_buffer #(.NUM_BANKS(NB), .BANK_BYTES(BB), .DATA_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_size(cfg_size),
      .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .sw_ready_ack(sw_ready_ack), .sw_release(sw_release),
      .sw_irq_en_set(sw_irq_en_set), .sw_irq_en_clr(sw_irq_en_clr),
      .bank_ready(bank_ready), .sw_own(sw_own), .wr_room(wr_room), .irq(irq),
      .sw_bank(sw_bank), .sw_count(sw_count),
      .in_token(in_token), .tx_ack(tx_ack), .tx_timeout(tx_timeout),
      .tx_valid(tx_valid), .tx_nak(tx_nak), .tx_bank(tx_bank), .tx_len(tx_len),
      .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data)
   );

   // {data[15:8], expected count[7:4], expected room[0]}
   localparam logic [15:0] WR_VEC [5] = '{
      {8'hA0, 4'd1, 4'd1}, {8'hA1, 4'd2, 4'd1}, {8'hA2, 4'd3, 4'd1},
      {8'hA3, 4'd4, 4'd0}, {8'hA4, 4'd4, 4'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // all stimulus tasks start and end just after a falling edge
   task automatic pulse_token();
      in_token = 1'b1; @(negedge clk); in_token = 1'b0;
   endtask
   task automatic pulse_ack();
      tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
   endtask
   task automatic pulse_timeout();
      tx_timeout = 1'b1; @(negedge clk); tx_timeout = 1'b0;
   endtask
   task automatic pulse_release();
      sw_release = 1'b1; @(negedge clk); sw_release = 1'b0;
   endtask
   task automatic write_byte(input logic [7:0] d);
      sw_wr_en = 1'b1; sw_wr_data = d; @(negedge clk); sw_wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset own", sw_own, 0);
      chk("R1 reset ready", bank_ready, 0);
      chk("R1 reset room", wr_room, 0);
      chk("R1 reset irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pulse_token();
      chk("R1 disabled no data", tx_valid, 0);
      chk("R1 disabled no nak", tx_nak, 0);

      cfg_en = 1'b1;
      @(negedge clk);
      chk("R2 own after enable", sw_own, 1);
      chk("R2 ready after enable", bank_ready, 1);
      chk("R3 irq masked", irq, 0);
      sw_irq_en_set = 1'b1; sw_irq_en_clr = 1'b1; @(negedge clk);
      sw_irq_en_set = 1'b0; sw_irq_en_clr = 1'b0;
      chk("R3 irq set wins", irq, 1);
      sw_ready_ack = 1'b1; @(negedge clk); sw_ready_ack = 1'b0;
      chk("R4 ready cleared", bank_ready, 0);
      chk("R4 own kept", sw_own, 1);
      chk("R3 irq follows ready", irq, 0);
      pulse_token();
      chk("R8 nak empty", tx_nak, 1);
      chk("R8 no data empty", tx_valid, 0);

      for (int i = 0; i < 5; i++) begin
         write_byte(WR_VEC[i][15:8]);
         chk("R10 count", sw_count, 32'(WR_VEC[i][7:4]));
         chk("R7 room", wr_room, 32'(WR_VEC[i][0]));
      end
      chk("R12 full write ignored", sw_count, 4);

      pulse_release();
      chk("R6 bank advanced", sw_bank, 1);
      chk("R6 own reload free", sw_own, 1);
      chk("R6 ready reload free", bank_ready, 1);
      chk("R6 new bank empty", sw_count, 0);
      chk("R3 irq on reload", irq, 1);

      pulse_token();
      chk("R5 data sent", tx_valid, 1);
      chk("R5 bank sent", tx_bank, 0);
      chk("R5 length", tx_len, 4);
      tx_rd_idx = 2'd2; #1;
      chk("R10 stored byte", tx_rd_data, 8'hA2);

      pulse_timeout();
      pulse_token();
      chk("R11 resent", tx_valid, 1);
      chk("R11 same bank", tx_bank, 0);
      chk("R11 same length", tx_len, 4);

      write_byte(8'hB0);
      write_byte(8'hB1);
      pulse_release();
      chk("R6 wrap bank", sw_bank, 0);
      chk("R6 own reload held", sw_own, 0);
      chk("R6 ready reload held", bank_ready, 0);
      write_byte(8'hEE);
      chk("R12 write without ownership", sw_count, 4);
      chk("R7 no room unowned", wr_room, 0);

      pulse_ack();
      chk("R9 bank freed own", sw_own, 1);
      chk("R2 ready on free", bank_ready, 1);
      chk("R9 count zeroed", sw_count, 0);
      pulse_token();
      chk("R9 next bank sent", tx_valid, 1);
      chk("R9 next bank index", tx_bank, 1);
      chk("R10 second length", tx_len, 2);
      tx_rd_idx = 2'd1; #1;
      chk("R10 second bank byte", tx_rd_data, 8'hB1);
      pulse_token();
      chk("R8 nak while busy", tx_nak, 1);
      pulse_ack();
      pulse_token();
      chk("R8 nak after drain", tx_nak, 1);

      pulse_release();
      pulse_token();
      chk("R10 zero length sent", tx_valid, 1);
      chk("R10 zero length", tx_len, 0);

      cfg_en = 1'b0;
      @(negedge clk);
      chk("R1 disable own", sw_own, 0);
      chk("R1 disable ready", bank_ready, 0);
      done = 1'b1;
      summary();
   end
endmodule